// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block holds the interrupt and wake status for a bank of GPIO pins. Each pin has a 12-bit control word that sets the trigger style, the interrupt enable, a separate unmask bit, three wake enables and plain drive storage. It takes the filtered level of each pin and watches it for a qualifying event. When that pin's interrupt enable is set, an event sets a sticky interrupt status bit. When the wake enable that matches the current sleep state is set, the same event also sets a sticky wake status bit.

Software writes a pin's whole control word through a simple write port. Any status bit written as one is cleared, and status bits written as zero are left alone. The read port returns the control word together with both status bits one cycle after the address is presented. A pin is pending when its wake status is set, or when its interrupt status is set and the pin is unmasked. The pending flags are registered, and `irq_any` is their OR.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous reset, every control word, status bit, `pend`, `irq_any`, `pin_oe`, `pin_out` and `rd_data` is zero.
- R2: Word layout, used for both write and read:
  - bit 0 selects the trigger style (1 = level, 0 = edge);
  - bits 2:1 hold the polarity code;
  - bit 3 is the interrupt enable;
  - bit 4 is unmask (1 = pending allowed);
  - bits 7:5 are the wake enables for sleep states 1, 2 and 3;
  - bit 8 is output enable and bit 9 is output value;
  - bit 10 is interrupt status and bit 11 is wake status.
  `rd_data` shows the word for `rd_addr` one clock after the address is presented. An address of `NUM_PINS` or above reads as zero.
- R3: In edge mode, polarity code 00 fires on a falling edge, 01 on a rising edge and 10 on either edge. Edges are measured against the level sampled on the previous clock.
- R4: In level mode, code 00 fires while the pin is low and 01 while it is high. A clear write drops the status for one cycle. The status is set again on the next cycle if the level is still active.
- R5: Polarity code 11, in either mode, and code 10 in level mode never produce an event.
- R6: Interrupt status latches only while the interrupt enable is set. The unmask bit has no effect on latching; it only gates the interrupt status into `pend`.
- R7: `pend[i]` is high when (interrupt status and unmask) or wake status holds, and it follows the status by one clock. Without a write, a set `pend[i]` stays set.
- R8: A status bit written as 1 is cleared by that write. A status bit written as 0 keeps its value.
- R9: In edge mode, an event on the same clock as a clear write wins, and the status stays set.
- R10: With `sleep_state` = 0, wake status never latches. With `sleep_state` = s (1 to 3), an event latches wake status if wake enable bit 4+s is set, whatever the interrupt enable holds.
- R11: `pin_oe[i]` and `pin_out[i]` equal bits 8 and 9 of pin i's word, starting from the clock of the write.
- R12: `irq_any` is high exactly when some `pend` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one pin's word |
| wr_addr | input | ADDR_W | Pin index for the write |
| wr_data | input | 12 | Word to write; status bits are write-one-to-clear |
| rd_addr | input | ADDR_W | Pin index for the read |
| rd_data | output | 12 | Registered read word |
| pin_lvl | input | NUM_PINS | Filtered pin levels, already synchronous |
| sleep_state | input | 2 | Current sleep state, 0 = running |
| pin_oe | output | NUM_PINS | Stored output enables |
| pin_out | output | NUM_PINS | Stored output values |
| pend | output | NUM_PINS | Registered per-pin pending flags |
| irq_any | output | 1 | OR of all pending flags |

## Verification
A pin change driven before clock edge k sets status at edge k. That status is visible on `rd_data` after the read edge that follows, and on `pend` only after edge k+1. The bench therefore checks `pend` one clock after the change, expecting it still low, and again one clock later, expecting it high. A write at edge k updates `pin_oe`, `pin_out` and the control word at that edge. In level mode a clear is seen as zero on the very next read, and as set again on the read after that; the bench issues both reads back to back to pin down that one-cycle gap. Every input is driven and every output is sampled on the falling edge, so each result is taken a whole number of register stages after its stimulus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W  = 12;
  localparam int CFG_W  = 10;
  localparam int F_LVL  = 0;
  localparam int F_POL  = 1;
  localparam int F_IEN  = 3;
  localparam int F_UNM  = 4;
  localparam int F_WAKE = 5;
  localparam int F_OE   = 8;
  localparam int F_OV   = 9;
  localparam int F_ISTS = 10;
  localparam int F_WSTS = 11;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_BAD  = 2'b11
  } pol_e;

  // packed MSB first: out_val is bit 9, lvl_mode is bit 0
  typedef struct packed {
    logic       out_val;
    logic       out_en;
    logic [2:0] wake_en;
    logic       unmask;
    logic       int_en;
    pol_e       pol;
    logic       lvl_mode;
  } pin_cfg_t;

  // sticky status update; a level-mode clear suppresses the same-cycle set
  function automatic logic sticky_next(logic cur, logic set, logic clr, logic lvl);
    if (lvl) return clr ? 1'b0 : (cur | set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic lvl_mode,
  input  pol_e pol,
  input  logic cur,
  input  logic prev,
  output logic hit
);
  logic rise, fall;
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    hit = 1'b0;
    if (lvl_mode) begin
      case (pol)
        POL_LOW:  hit = ~cur;
        POL_HIGH: hit = cur;
        default:  hit = 1'b0;
      endcase
    end else begin
      case (pol)
        POL_LOW:  hit = fall;
        POL_HIGH: hit = rise;
        POL_BOTH: hit = rise | fall;
        default:  hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] wr_word,
  input  logic             pin_lvl,
  input  logic [1:0]       sleep_state,
  output pin_cfg_t         cfg_q,
  output logic             int_sts_q,
  output logic             wake_sts_q,
  output logic             pend_q
);
  logic prev_q, hit, wake_arm;
  logic int_set, wake_set, int_clr, wake_clr;

  gpio_irq_trig u_trig (
    .lvl_mode (cfg_q.lvl_mode),
    .pol      (cfg_q.pol),
    .cur      (pin_lvl),
    .prev     (prev_q),
    .hit      (hit)
  );

  always_comb begin
    case (sleep_state)
      2'd1:    wake_arm = cfg_q.wake_en[0];
      2'd2:    wake_arm = cfg_q.wake_en[1];
      2'd3:    wake_arm = cfg_q.wake_en[2];
      default: wake_arm = 1'b0;
    endcase
  end

  assign int_set  = cfg_q.int_en & hit;
  assign wake_set = wake_arm & hit;
  assign int_clr  = cfg_we & wr_word[F_ISTS];
  assign wake_clr = cfg_we & wr_word[F_WSTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      prev_q     <= 1'b0;
      int_sts_q  <= 1'b0;
      wake_sts_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      prev_q     <= pin_lvl;
      if (cfg_we) cfg_q <= pin_cfg_t'(wr_word[CFG_W-1:0]);
      int_sts_q  <= sticky_next(int_sts_q, int_set, int_clr, cfg_q.lvl_mode);
      wake_sts_q <= sticky_next(wake_sts_q, wake_set, wake_clr, cfg_q.lvl_mode);
      pend_q     <= (int_sts_q & cfg_q.unmask) | wake_sts_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [1:0]          sleep_state,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pend,
  output logic                irq_any
);
  pin_cfg_t            cfg_a [NUM_PINS];
  logic [NUM_PINS-1:0] ists, wsts;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic we;
    assign we = wr_en && (int'(wr_addr) == i);

    gpio_irq_pin u_pin (
      .clk         (clk),
      .rst         (rst),
      .cfg_we      (we),
      .wr_word     (wr_data),
      .pin_lvl     (pin_lvl[i]),
      .sleep_state (sleep_state),
      .cfg_q       (cfg_a[i]),
      .int_sts_q   (ists[i]),
      .wake_sts_q  (wsts[i]),
      .pend_q      (pend[i])
    );

    assign pin_oe[i]  = cfg_a[i].out_en;
    assign pin_out[i] = cfg_a[i].out_val;
  end

  assign irq_any = |pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_addr) < NUM_PINS) begin
      rd_data <= {wsts[rd_addr], ists[rd_addr], cfg_a[rd_addr]};
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [REG_W-1:0]    wr_data,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [REG_W-1:0]    rd_data,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pend
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend == '0 && rd_data == '0 && pin_oe == '0 && pin_out == '0)); // R1

  AST_DRIVE_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < NUM_PINS) |=>
      (pin_oe[$past(wr_addr)] == $past(wr_data[F_OE]) &&
       pin_out[$past(wr_addr)] == $past(wr_data[F_OV]))); // R11

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_data[F_ISTS] && !$past(wr_en) && rd_addr == $past(rd_addr)) |=> rd_data[F_ISTS]); // R8

  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_data[F_WSTS] && !$past(wr_en) && rd_addr == $past(rd_addr)) |=> rd_data[F_WSTS]); // R10

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hold
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !$past(wr_en)) |=> pend[i]); // R7
  end
endmodule

bind gpio_irq_detect gpio_irq_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .pin_oe  (pin_oe),
  .pin_out (pin_out),
  .pend    (pend)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [11:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [11:0]   rd_data;
  logic [N-1:0]  pin_lvl = '0;
  logic [1:0]    sleep_state = 2'd0;
  logic [N-1:0]  pin_oe, pin_out, pend;
  logic          irq_any;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_lvl(pin_lvl),
    .sleep_state(sleep_state), .pin_oe(pin_oe), .pin_out(pin_out),
    .pend(pend), .irq_any(irq_any)
  );

  localparam logic [11:0] ISTS = 12'h400;
  localparam logic [11:0] WSTS = 12'h800;

  function automatic logic [11:0] mk(bit lvl, logic [1:0] pol, bit ien, bit unm,
                                     logic [2:0] wk, bit oe, bit ov);
    return {2'b00, ov, oe, wk, unm, ien, pol, lvl};
  endfunction

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int p, logic [11:0] d);
    wr_en = 1'b1; wr_addr = AW'(p); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(int p, output logic [11:0] d);
    rd_addr = AW'(p);
    tick();
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [11:0] d;
    chk("R1 pend", pend, 0);
    chk("R1 irq_any", irq_any, 0);
    chk("R1 oe/out", {pin_oe, pin_out}, 0);
    rd(0, d);
    chk("R1 rd word", d, 0);
  endtask

  task automatic t_regs();
    logic [11:0] d;
    wr(1, 12'h3FF);
    chk("R11 oe", pin_oe[1], 1);
    chk("R11 out", pin_out[1], 1);
    rd(1, d);
    chk("R2 readback", d, 12'h3FF);
    pin_lvl[1] = 1'b1; tick(2); pin_lvl[1] = 1'b0; tick(2);
    rd(1, d);
    chk("R5 level code 11 no status", d[10], 0);
    wr(1, mk(0, 2'b11, 1, 1, 3'b000, 0, 1));
    chk("R11 oe cleared", pin_oe[1], 0);
    pin_lvl[1] = 1'b1; tick(2); pin_lvl[1] = 1'b0; tick(2);
    rd(1, d);
    chk("R5 edge code 11 no status", d[10], 0);
    wr(1, 12'h000);
  endtask

  task automatic t_edges();
    logic [11:0] c, d;
    c = mk(0, 2'b01, 1, 1, 3'b000, 0, 0);
    wr(2, c);
    pin_lvl[2] = 1'b1; tick();
    chk("R7 pend latency", pend[2], 0);
    tick();
    chk("R7 pend after status", pend[2], 1);
    chk("R12 irq_any", irq_any, 1);
    rd(2, d);
    chk("R3 rising", d[10], 1);
    wr(2, c | ISTS);
    rd(2, d);
    chk("R8 clear", d[10], 0);
    pin_lvl[2] = 1'b0; tick();
    rd(2, d);
    chk("R3 fall ignored in rise mode", d[10], 0);
    c = mk(0, 2'b00, 1, 1, 3'b000, 0, 0);
    wr(2, c);
    pin_lvl[2] = 1'b1; tick();
    rd(2, d);
    chk("R3 rise ignored in fall mode", d[10], 0);
    pin_lvl[2] = 1'b0; tick();
    rd(2, d);
    chk("R3 falling", d[10], 1);
    c = mk(0, 2'b10, 1, 1, 3'b000, 0, 0);
    wr(2, c | ISTS);
    pin_lvl[2] = 1'b1; tick();
    rd(2, d);
    chk("R3 both rise", d[10], 1);
    wr(2, c | ISTS);
    rd(2, d);
    chk("R8 clear both", d[10], 0);
    pin_lvl[2] = 1'b0; tick();
    rd(2, d);
    chk("R3 both fall", d[10], 1);
    wr(2, c);
    rd(2, d);
    chk("R8 zero keeps status", d[10], 1);
    wr(2, ISTS | WSTS);
  endtask

  task automatic t_level();
    logic [11:0] c, d;
    c = mk(1, 2'b01, 1, 1, 3'b000, 0, 0);
    wr(3, c);
    rd(3, d);
    chk("R4 high mode pin low", d[10], 0);
    pin_lvl[3] = 1'b1; tick();
    rd(3, d);
    chk("R4 high mode pin high", d[10], 1);
    wr(3, c | ISTS);
    rd(3, d);
    chk("R4 clear drops one cycle", d[10], 0);
    rd(3, d);
    chk("R4 reasserts", d[10], 1);
    c = mk(1, 2'b00, 1, 1, 3'b000, 0, 0);
    wr(3, c | ISTS);
    rd(3, d);
    chk("R4 low mode pin high", d[10], 0);
    pin_lvl[3] = 1'b0; tick();
    rd(3, d);
    chk("R4 low mode pin low", d[10], 1);
    c = mk(1, 2'b10, 1, 1, 3'b000, 0, 0);
    wr(3, c | ISTS);
    pin_lvl[3] = 1'b1; tick(2); pin_lvl[3] = 1'b0; tick(2);
    rd(3, d);
    chk("R5 level code 10 no status", d[10], 0);
    wr(3, ISTS | WSTS);
  endtask

  task automatic t_mask();
    logic [11:0] c, d;
    c = mk(0, 2'b01, 1, 0, 3'b000, 0, 0);
    wr(4, c);
    pin_lvl[4] = 1'b1; tick(2);
    chk("R6 masked pend low", pend[4], 0);
    rd(4, d);
    chk("R6 masked still latches", d[10], 1);
    wr(4, c | 12'h010);
    tick();
    chk("R6 unmask raises pend", pend[4], 1);
    wr(4, mk(0, 2'b01, 0, 1, 3'b000, 0, 0) | ISTS);
    pin_lvl[4] = 1'b0; tick(); pin_lvl[4] = 1'b1; tick(2);
    rd(4, d);
    chk("R6 disabled no latch", d[10], 0);
    chk("R12 irq_any low", {pend, irq_any}, 0);
    pin_lvl[4] = 1'b0;
    wr(4, ISTS | WSTS);
  endtask

  task automatic t_wake();
    logic [11:0] c, d;
    c = mk(0, 2'b01, 0, 0, 3'b010, 0, 0);
    wr(5, c);
    sleep_state = 2'd0;
    pin_lvl[5] = 1'b1; tick(); pin_lvl[5] = 1'b0; tick();
    rd(5, d);
    chk("R10 running no wake", d[11], 0);
    sleep_state = 2'd3;
    pin_lvl[5] = 1'b1; tick(); pin_lvl[5] = 1'b0; tick();
    rd(5, d);
    chk("R10 other state no wake", d[11], 0);
    sleep_state = 2'd2;
    pin_lvl[5] = 1'b1; tick();
    rd(5, d);
    chk("R10 matching state wake", d[11:10], 2'b10);
    chk("R7 wake pends", pend[5], 1);
    wr(5, c | WSTS);
    rd(5, d);
    chk("R8 wake clear", d[11], 0);
    sleep_state = 2'd0;
    pin_lvl[5] = 1'b0;
    wr(5, ISTS | WSTS);
  endtask

  task automatic t_collide();
    logic [11:0] c, d;
    c = mk(0, 2'b01, 1, 1, 3'b000, 0, 0);
    wr(6, c);
    pin_lvl[6] = 1'b1; tick();
    pin_lvl[6] = 1'b0; tick();
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = c | ISTS; pin_lvl[6] = 1'b1;
    tick();
    wr_en = 1'b0;
    rd(6, d);
    chk("R9 event beats clear", d[10], 1);
    pin_lvl[6] = 1'b0;
    wr(6, ISTS | WSTS);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_edges();
    t_level();
    t_mask();
    t_wake();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule